// File: doc/BRIEF.md
# Serial Receive Buffer with Data-Ready Interrupt

This block is the receive side of a classic asynchronous serial port. It watches the incoming serial line using a clock enable pulsed at sixteen times the baud rate. It qualifies each start bit, shifts in eight data bits least significant bit first, and checks the stop bit. Each finished character then goes to a receive store. That store is either a single holding slot or a 16-entry first-in first-out queue, selected by a mode bit. A data-ready interrupt, gated by an enable bit, tells the host that characters are waiting.

The host reaches the block over a small word-addressed register bus with combinational read data. Reads take effect on the clock edge at which the select is sampled. One address is shared by three registers: received data, the transmit holding byte and the low byte of the baud divisor. A divisor-access bit steers that address between them. The divisor low byte also has an alias address of its own, so software can leave the divisor-access bit clear. Address map: 0 shared, 1 interrupt enable (bit 0), 2 queue control (bit 0 queue enable, bits 2:1 threshold select), 3 line control (bit 7 divisor access), 4 divisor low alias, 5 status (bit 0 data waiting, bit 1 overrun).

Top module: `uart_rx_buf`

## Requirements
- R1: A start bit is accepted only when the synchronised line is still low on the eighth baud tick after the falling edge is seen; a low pulse shorter than that stores no character (status bit 0 stays 0).
- R2: Each frame is one start bit, 8 data bits LSB first, each sampled at its sixteen-tick midpoint, and one stop bit; the character is stored only when the stop bit samples high.
- R3: With queue enable 0 the store is one holding slot; with interrupt enable 1, irq goes high once a character is held and goes low when that character is read at address 0 with divisor access 0.
- R4: With queue enable 1 the store holds up to 16 characters, returned in arrival order.
- R5: In queue mode, threshold select 0/1/2/3 means a level of 1/4/8/14. With interrupt enable 1, irq is high whenever the stored count is at least the level, and low once it falls below.
- R6: A character arriving while the store is full (1 entry in holding mode, 16 in queue mode) is discarded and sets status bit 1, which stays set until status (address 5) is read.
- R7: A data read at address 0 with an empty store returns 0 and leaves the store untouched, so the next character is returned correctly.
- R8: With divisor access 0, address 0 reads received data and writes the transmit holding byte; with divisor access 1, both reads and writes at address 0 reach the divisor low byte, and such a read removes no character.
- R9: Address 4 reads and writes the divisor low byte whatever the divisor access bit.
- R10: After reset all registers, irq and both byte outputs are 0, and a received-data read always returns 0 in bits 31:8.
- R11: A write that changes the queue enable bit empties the store.
- R12: With interrupt enable 0, irq stays low whatever the store holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Clock enable at 16x baud rate |
| rxd | input | 1 | Serial receive line, idles high |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| irq | output | 1 | Data-ready interrupt |
| tx_hold | output | 8 | Transmit holding byte |
| div_low | output | 8 | Divisor low byte |

## Verification
A wrong read or write pointer in the queue shows up as bytes out of order or repeated on the next data read. A wrong fill count shows up as irq changing one character early or late against the threshold, visible as soon as the affected character lands. A faulty sampling counter corrupts the received byte or drops a frame, and this is seen at the first read after that frame. Overrun and divisor-access faults show up within a single status or alias read, because each access returns the state it touched directly.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 8;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_SHARED = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN    = 3'd1;
    localparam logic [ADDR_W-1:0] A_QCTL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_LCTL   = 3'd3;
    localparam logic [ADDR_W-1:0] A_DIVLO  = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rx_char_t;

    typedef struct packed {
        logic       q_en;
        logic [1:0] thr_sel;
    } qctl_t;

    function automatic int unsigned thresh_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    output rx_char_t chr
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] IDX_LAST = BIT_W'(DATA_W - 1);

    logic [1:0]        sync_q;
    logic              rx_s;
    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;

    assign rx_s = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            chr     <= '0;
        end else begin
            chr.valid <= 1'b0;
            if (tick) begin
                case (state_q)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            state_q <= RX_START;
                            cnt_q   <= CNT_W'(1);
                        end
                    end
                    RX_START: begin
                        if (cnt_q == MID_LAST) begin
                            cnt_q <= '0;
                            idx_q <= '0;
                            state_q <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt_q == BIT_LAST) begin
                            cnt_q   <= '0;
                            shreg_q <= {rx_s, shreg_q[DATA_W-1:1]};
                            idx_q   <= idx_q + 1'b1;
                            if (idx_q == IDX_LAST) state_q <= RX_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        if (cnt_q == BIT_LAST) begin
                            cnt_q   <= '0;
                            state_q <= RX_IDLE;
                            if (rx_s) begin
                                chr.valid <= 1'b1;
                                chr.data  <= shreg_q;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        chr.valid |=> !chr.valid); // R2

    AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
        (tick && state_q == RX_START && cnt_q == MID_LAST && rx_s) |=> state_q == RX_IDLE); // R1

    AST_BAD_STOP: assert property (@(posedge clk) disable iff (rst)
        (tick && state_q == RX_STOP && cnt_q == BIT_LAST && !rx_s) |=> !chr.valid); // R2

endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    input  logic              q_en,
    input  logic              ovr_clr,
    output logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] head,
    output logic              ovr
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q, cap;
    logic              full, push_ok, pop_ok;

    assign cap     = q_en ? CNT_W'(DEPTH) : CNT_W'(1);
    assign full    = (cnt_q >= cap);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && (cnt_q != '0) && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= wr_q + 1'b1;
            if (pop_ok)  rd_q <= rd_q + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst)                          ovr <= 1'b0;
        else if (push && full && !flush)  ovr <= 1'b1;
        else if (ovr_clr)                 ovr <= 1'b0;
    end

    assign count = cnt_q;
    assign head  = (cnt_q != '0) ? mem_q[rd_q] : '0;

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH)); // R4

    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (push && full && !flush) |=> ovr); // R6

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && cnt_q == '0 && !push && !flush) |=> (cnt_q == '0 && $stable(rd_q))); // R7

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> cnt_q == '0); // R11

endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
    import uart_rx_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-1:0] head,
    input  logic              ovr,
    output logic              pop,
    output logic              ovr_clr,
    output logic              flush,
    output logic              q_en,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq,
    output logic [DATA_W-1:0] dll_q,
    output logic [DATA_W-1:0] thr_q
);
    logic  ien_q, dlab_q, wr, rd;
    qctl_t qctl_q;

    assign wr = sel && we;
    assign rd = sel && !we;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= 1'b0;
            dlab_q <= 1'b0;
            qctl_q <= '0;
            dll_q  <= '0;
            thr_q  <= '0;
        end else if (wr) begin
            case (addr)
                A_SHARED: begin
                    if (dlab_q) dll_q <= wdata[DATA_W-1:0];
                    else        thr_q <= wdata[DATA_W-1:0];
                end
                A_IEN:   ien_q  <= wdata[0];
                A_QCTL:  qctl_q <= '{q_en: wdata[0], thr_sel: wdata[2:1]};
                A_LCTL:  dlab_q <= wdata[7];
                A_DIVLO: dll_q  <= wdata[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    assign flush   = wr && (addr == A_QCTL) && (wdata[0] != qctl_q.q_en);
    assign pop     = rd && (addr == A_SHARED) && !dlab_q;
    assign ovr_clr = rd && (addr == A_STAT);
    assign q_en    = qctl_q.q_en;

    always_comb begin
        rdata = '0;
        case (addr)
            A_SHARED: rdata[DATA_W-1:0] = dlab_q ? dll_q : head;
            A_IEN:    rdata[0]          = ien_q;
            A_QCTL:   rdata[2:0]        = {qctl_q.thr_sel, qctl_q.q_en};
            A_LCTL:   rdata[7]          = dlab_q;
            A_DIVLO:  rdata[DATA_W-1:0] = dll_q;
            A_STAT:   rdata[1:0]        = {ovr, count != '0};
            default:  rdata = '0;
        endcase
    end

    always_comb begin
        if (!ien_q)           irq = 1'b0;
        else if (qctl_q.q_en) irq = (32'(count) >= thresh_level(qctl_q.thr_sel));
        else                  irq = (count != '0);
    end

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr && (addr == A_DIVLO || (addr == A_SHARED && dlab_q))) |=> $stable(dll_q)); // R9

    AST_THR_SHIELD: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_SHARED && dlab_q) |=> $stable(thr_q)); // R8

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_IEN && !wdata[0]) |=> !irq); // R12

    AST_RD_UPPER: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_SHARED) |-> rdata[BUS_W-1:DATA_W] == '0); // R10

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        baud_tick,
    input  logic        rxd,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic [7:0]  tx_hold,
    output logic [7:0]  div_low
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_char_t          chr;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] head;
    logic              ovr, pop, ovr_clr, flush, q_en;

    uart_rx_deser #(.OVS(OVS)) u_deser (
        .clk  (clk),
        .rst  (rst),
        .tick (baud_tick),
        .rxd  (rxd),
        .chr  (chr)
    );

    uart_rx_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (chr.valid),
        .push_data (chr.data),
        .pop       (pop),
        .flush     (flush),
        .q_en      (q_en),
        .ovr_clr   (ovr_clr),
        .count     (count),
        .head      (head),
        .ovr       (ovr)
    );

    uart_rx_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel     (bus_sel),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .count   (count),
        .head    (head),
        .ovr     (ovr),
        .pop     (pop),
        .ovr_clr (ovr_clr),
        .flush   (flush),
        .q_en    (q_en),
        .rdata   (bus_rdata),
        .irq     (irq),
        .dll_q   (div_low),
        .thr_q   (tx_hold)
    );

    AST_HOLD_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
        (pop && !q_en && count == CNT_W'(1) && !chr.valid) |=> !irq); // R3

endmodule

// File: tb/uart_rx_buf_tb.sv
`timescale 1ns/1ps
module uart_rx_buf_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [7:0]  tx_hold, div_low;
    logic [1:0]  tdiv;
    logic        baud_tick;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0]  mq[$];
    bit          m_ovr;
    logic [31:0] rv;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) tdiv <= '0;
        else     tdiv <= tdiv + 2'd1;
    end
    assign baud_tick = (tdiv == 2'd3);

    uart_rx_buf u_dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .tx_hold(tx_hold), .div_low(div_low)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #3 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit good_stop);
        rxd = 1'b0;
        repeat (64) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (64) @(negedge clk);
        end
        if (good_stop) begin
            rxd = 1'b1;
            repeat (64) @(negedge clk);
        end else begin
            rxd = 1'b0;
            repeat (44) @(negedge clk);
            rxd = 1'b1;
            repeat (40) @(negedge clk);
        end
        repeat (16) @(negedge clk);
    endtask

    function automatic int level_of(input logic [1:0] sel);
        case (sel)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit exp_irq(input int cnt, input bit qmode, input logic [1:0] sel, input bit ien);
        if (!ien) return 1'b0;
        if (qmode) return cnt >= level_of(sel);
        return cnt != 0;
    endfunction

    task automatic model_push(input logic [7:0] b, input bit qmode);
        if (mq.size() < (qmode ? 16 : 1)) mq.push_back(b);
        else m_ovr = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [1:0] tsel;
        int         n;
        logic [7:0] b;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R10 reset state
        chk(irq == 1'b0, "R10 irq after reset", irq, 0);
        chk(div_low == 8'h00 && tx_hold == 8'h00, "R10 byte outputs after reset", {div_low, tx_hold}, 0);
        bus_rd(3'd0, rv); chk(rv == 0, "R10 data reads 0", rv, 0);
        bus_rd(3'd5, rv); chk(rv == 0, "R10 status after reset", rv, 0);

        // R8 / R9 divisor access and shared address
        bus_wr(3'd3, 32'h80);
        bus_wr(3'd0, 32'h5A);
        bus_rd(3'd4, rv); chk(rv == 32'h5A, "R9 alias sees shared write", rv, 32'h5A);
        chk(tx_hold == 8'h00, "R8 holding byte untouched with access=1", tx_hold, 0);
        bus_wr(3'd4, 32'h3C);
        bus_rd(3'd0, rv); chk(rv == 32'h3C, "R8 shared reads divisor with access=1", rv, 32'h3C);
        bus_wr(3'd3, 32'h00);
        bus_wr(3'd0, 32'hFFFF_FFA7);
        chk(tx_hold == 8'hA7, "R8 shared write goes to holding byte", tx_hold, 8'hA7);
        chk(div_low == 8'h3C, "R9 divisor kept", div_low, 8'h3C);
        bus_rd(3'd4, rv); chk(rv == 32'h3C, "R9 alias read with access=0", rv, 32'h3C);

        // R3 / R6 / R7 single holding slot
        bus_wr(3'd1, 32'h1);
        send(8'h96, 1'b1);
        chk(irq == 1'b1, "R3 irq on held character", irq, 1);
        send(8'h21, 1'b1);
        bus_rd(3'd5, rv); chk(rv == 32'h3, "R6 overrun and data waiting", rv, 32'h3);
        bus_rd(3'd5, rv); chk(rv == 32'h1, "R6 overrun cleared by status read", rv, 32'h1);
        bus_wr(3'd3, 32'h80);
        bus_rd(3'd0, rv); chk(rv == 32'h3C, "R8 divisor read at shared", rv, 32'h3C);
        chk(irq == 1'b1, "R8 divisor read removes no character", irq, 1);
        bus_wr(3'd3, 32'h00);
        bus_rd(3'd0, rv); chk(rv == 32'h96, "R2 R3 first character kept", rv, 32'h96);
        chk(irq == 1'b0, "R3 irq cleared by read", irq, 0);
        bus_rd(3'd0, rv); chk(rv == 0, "R7 empty read", rv, 0);
        send(8'h55, 1'b1);
        bus_rd(3'd0, rv); chk(rv == 32'h55, "R7 store intact after empty read", rv, 32'h55);

        // R1 short low pulse
        rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
        repeat (700) @(negedge clk);
        bus_rd(3'd5, rv); chk(rv == 0, "R1 glitch stores nothing", rv, 0);

        // R2 low stop bit
        send(8'h3E, 1'b0);
        bus_rd(3'd5, rv); chk(rv == 0, "R2 bad stop discarded", rv, 0);
        send(8'hC3, 1'b1);
        bus_rd(3'd0, rv); chk(rv == 32'hC3, "R2 next frame after bad stop", rv, 32'hC3);

        // R12 interrupt disabled
        bus_wr(3'd1, 32'h0);
        send(8'h0F, 1'b1);
        chk(irq == 1'b0, "R12 irq masked", irq, 0);
        bus_rd(3'd5, rv); chk(rv == 32'h1, "R12 character still stored", rv, 32'h1);

        // R11 mode change empties store
        bus_wr(3'd2, 32'h1);
        bus_rd(3'd5, rv); chk(rv == 0, "R11 store emptied on mode change", rv, 0);
        bus_wr(3'd1, 32'h1);

        // R4 / R5 / R6 queue mode, directed full case then random rounds
        for (int r = 0; r < 5; r++) begin
            if (r == 0) begin tsel = 2'd3; n = 17; end
            else begin tsel = 2'($urandom_range(0, 3)); n = $urandom_range(0, 16); end
            bus_wr(3'd2, 32'h0);
            bus_wr(3'd2, {29'd0, tsel, 1'b1});
            mq.delete(); m_ovr = 1'b0;
            for (int k = 0; k < n; k++) begin
                b = 8'($urandom_range(0, 255));
                send(b, 1'b1);
                model_push(b, 1'b1);
                chk(irq == exp_irq(mq.size(), 1'b1, tsel, 1'b1), "R5 irq vs level on fill",
                    irq, exp_irq(mq.size(), 1'b1, tsel, 1'b1));
            end
            bus_rd(3'd5, rv);
            chk(rv == {30'd0, m_ovr, mq.size() != 0}, "R6 status after fill", rv, {30'd0, m_ovr, mq.size() != 0});
            while (mq.size() != 0) begin
                bus_rd(3'd0, rv);
                chk(rv == {24'd0, mq[0]}, "R4 queue order", rv, {24'd0, mq[0]});
                void'(mq.pop_front());
                chk(irq == exp_irq(mq.size(), 1'b1, tsel, 1'b1), "R5 irq vs level on drain",
                    irq, exp_irq(mq.size(), 1'b1, tsel, 1'b1));
            end
            bus_rd(3'd0, rv); chk(rv == 0, "R7 empty queue read", rv, 0);
        end

        done = 1'b1;
        finish_run();
    end

endmodule